// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block keeps the control and status word of a scalar floating-point coprocessor, together with a read-only revision register. Software reaches both through control-register move instructions: a write port that carries a register index and a 32-bit value, and a read port whose answer goes to a general-purpose register. The word's rounding-mode field and its flush-denormals setting are presented to the arithmetic units as plain levels.

Each finished arithmetic operation reports its exception bits on a valid/ready stream. The operation's exceptions replace the cause field, and the five IEEE exceptions are also ORed into the sticky flags. In the same cycle the block compares the operation's causes against the enable field. If a trap is needed it raises a trap request and tells the register-file write port to drop that operation's result.

A software write of the word is checked in the same way. If it leaves a cause bit set together with its enable, it requests a trap at once. The operation stream has `op_ready` tied high and never stalls. The write port is held off (`ctl_wr_ready` low) in any cycle where an operation report is valid, so the two never update the word in the same cycle. A write is applied only in a cycle where `ctl_wr_valid` and `ctl_wr_ready` are both high. The read port has no handshake: a request is answered one cycle later.

Top module: `fpu_ctrl_status`

## Requirements
- R1: After reset the status word reads zero, `round_mode` is 0 (round to nearest), `flush_denorm` is 0, and no trap is requested.
- R2: An accepted write to index 31 stores the writable bits: 1:0 rounding mode (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf), 6:2 flags, 11:7 enables, 17:12 cause, and 24 flush. All other bits read as zero. From the next cycle `round_mode` equals bits 1:0 and `flush_denorm` equals bit 24.
- R3: A read of index 0, the revision register, returns zero, and so does a read of any index other than 31. A write to any index other than 31 changes nothing.
- R4: A read request is answered in the next cycle with `rd_rsp_valid`, `rd_rsp_gpr` and `rd_rsp_data`. The data is the value held in the request cycle. A request whose destination register is 0 produces no response.
- R5: An accepted operation report replaces the whole cause field (bits 17:12) with `op_exc`. In `op_exc`, bit 0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid and 5 unimplemented-operation.
- R6: Each of `op_exc[4:0]` is ORed into flag bit 2+i. Arithmetic reports never clear a flag.
- R7: In an operation-report cycle, `trap_req` and `wb_suppress` are high together, in that same cycle, exactly when some `op_exc[i]` (i<5) is set with enable bit 7+i set, or when `op_exc[5]` is set. The unimplemented-operation bit has no enable.
- R8: An accepted write to index 31 whose data has cause bit 12+i and enable bit 7+i both set, or cause bit 17 set, raises `trap_req` in that cycle without `wb_suppress`.
- R9: `op_ready` is always high. `ctl_wr_ready` is low whenever `op_valid` is high, and a write offered in such a cycle leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_valid | input | 1 | Control write offered |
| ctl_wr_ready | output | 1 | Control write can be accepted |
| ctl_wr_idx | input | 5 | Control register index for the write |
| ctl_wr_data | input | 32 | Write value |
| ctl_rd_valid | input | 1 | Control read request |
| ctl_rd_idx | input | 5 | Control register index for the read |
| ctl_rd_gpr | input | 5 | Destination general register of the read |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_gpr | output | 5 | Destination register of the response |
| rd_rsp_data | output | 32 | Read value |
| op_valid | input | 1 | Operation exception report valid |
| op_ready | output | 1 | Report accepted (always high) |
| op_exc | input | 6 | Operation exception bits |
| round_mode | output | 2 | Rounding mode to the datapath |
| flush_denorm | output | 1 | Flush-denormals level to the datapath |
| trap_req | output | 1 | Trap request |
| wb_suppress | output | 1 | Drop the current operation's result |

## Verification
The bench drives operations that carry several exceptions while the flags already hold set bits. A design that ORed into the cause field would leave stale cause bits, and one that wrote the flags instead of ORing them would clear flags that should stay set. The bench also lines up each cause bit against enables that are shifted by one position, and sends unimplemented-operation reports with every enable clear. Either case exposes an off-by-one in the trap comparison or a missing always-trap path. Further cases are writes that trap by themselves without suppressing write-back, writes held off during an operation, reads of index 0 and of stray indexes, and reads aimed at register 0, which a wrong design would answer.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 5;
  localparam int N_IEEE   = 5;
  localparam int N_CAUSE  = N_IEEE + 1;
  localparam int RM_LSB   = 0;
  localparam int FLG_LSB  = 2;
  localparam int ENA_LSB  = FLG_LSB + N_IEEE;
  localparam int CAU_LSB  = ENA_LSB + N_IEEE;
  localparam int FLUSH_BIT = 24;
  localparam logic [IDX_W-1:0] IDX_STATUS = 5'd31;
  localparam logic [IDX_W-1:0] IDX_REVID  = 5'd0;

  typedef struct packed {
    logic                 flush;
    logic [N_CAUSE-1:0]   cause;
    logic [N_IEEE-1:0]    enable;
    logic [N_IEEE-1:0]    flags;
    logic [1:0]           rm;
  } fcsr_t;

  function automatic logic [WORD_W-1:0] pack_word(input fcsr_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[RM_LSB +: 2]         = s.rm;
    w[FLG_LSB +: N_IEEE]   = s.flags;
    w[ENA_LSB +: N_IEEE]   = s.enable;
    w[CAU_LSB +: N_CAUSE]  = s.cause;
    w[FLUSH_BIT]           = s.flush;
    return w;
  endfunction

  function automatic fcsr_t unpack_word(input logic [WORD_W-1:0] w);
    fcsr_t s;
    s.rm     = w[RM_LSB +: 2];
    s.flags  = w[FLG_LSB +: N_IEEE];
    s.enable = w[ENA_LSB +: N_IEEE];
    s.cause  = w[CAU_LSB +: N_CAUSE];
    s.flush  = w[FLUSH_BIT];
    return s;
  endfunction
endpackage

// File: rtl/fcsr_trap_eval.sv
module fcsr_trap_eval #(
  parameter int N_EN = 5
) (
  input  logic [N_EN:0]   cause,
  input  logic [N_EN-1:0] enable,
  output logic            trap
);
  logic [N_EN:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_EN; gi++) begin : g_pair
      assign hit[gi] = cause[gi] & enable[gi];
    end
  endgenerate

  // the top cause bit has no enable: it always traps
  assign hit[N_EN] = cause[N_EN];
  assign trap = |hit;
endmodule

// File: rtl/fcsr_state.sv
module fcsr_state
  import fcsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic               op_fire,
  input  logic [N_CAUSE-1:0] op_exc,
  output fcsr_t              state
);
  fcsr_t nxt;
  fcsr_t wr_view;

  assign wr_view = unpack_word(wr_word);

  always_comb begin
    nxt = state;
    if (wr_fire) begin
      nxt = wr_view;
    end else if (op_fire) begin
      nxt.cause = op_exc;
      nxt.flags = state.flags | op_exc[N_IEEE-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= '0;
    else        state <= nxt;
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_fire) && !$past(wr_fire) |-> ((state.flags & $past(state.flags)) == $past(state.flags))); // R6

  AST_CAUSE_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_fire) && !$past(wr_fire) |-> state.cause == $past(op_exc)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_fire) && !$past(wr_fire) |-> $stable(state)); // R3
endmodule

// File: rtl/fcsr_read_port.sv
module fcsr_read_port
  import fcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rd_gpr,
  input  logic [WORD_W-1:0] status_word,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_gpr,
  output logic [WORD_W-1:0] rsp_data
);
  logic              keep;
  logic [WORD_W-1:0] sel;

  assign keep = rd_valid && (rd_gpr != '0);

  always_comb begin
    case (rd_idx)
      IDX_STATUS: sel = status_word;
      IDX_REVID:  sel = '0;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_gpr   <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= keep;
      if (keep) begin
        rsp_gpr  <= rd_gpr;
        rsp_data <= sel;
      end
    end
  end

  AST_GPR0_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_gpr != '0); // R4

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_gpr != '0 |=> rsp_valid && rsp_gpr == $past(rd_gpr)); // R4

  AST_REVID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_gpr != '0 && rd_idx != IDX_STATUS |=> rsp_data == '0); // R3
endmodule

// File: rtl/fpu_ctrl_status.sv
module fpu_ctrl_status
  import fcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_valid,
  output logic              ctl_wr_ready,
  input  logic [4:0]        ctl_wr_idx,
  input  logic [31:0]       ctl_wr_data,
  input  logic              ctl_rd_valid,
  input  logic [4:0]        ctl_rd_idx,
  input  logic [4:0]        ctl_rd_gpr,
  output logic              rd_rsp_valid,
  output logic [4:0]        rd_rsp_gpr,
  output logic [31:0]       rd_rsp_data,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [5:0]        op_exc,
  output logic [1:0]        round_mode,
  output logic              flush_denorm,
  output logic              trap_req,
  output logic              wb_suppress
);
  fcsr_t             st;
  fcsr_t             wr_view;
  logic              wr_fire;
  logic              wr_status;
  logic              op_fire;
  logic              op_trap;
  logic              wr_trap;
  logic [WORD_W-1:0] word_now;
  logic [WORD_W-1:0] wr_clean;

  assign op_ready     = 1'b1;
  assign ctl_wr_ready = !op_valid;
  assign op_fire      = op_valid && op_ready;
  assign wr_status    = ctl_wr_idx == IDX_STATUS;
  assign wr_fire      = ctl_wr_valid && ctl_wr_ready && wr_status;
  assign wr_view      = unpack_word(ctl_wr_data);
  assign wr_clean     = pack_word(wr_view);
  assign word_now     = pack_word(st);

  fcsr_state u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_word (wr_clean),
    .op_fire (op_fire),
    .op_exc  (op_exc),
    .state   (st)
  );

  fcsr_trap_eval #(.N_EN(N_IEEE)) u_op_trap (
    .cause  (op_exc),
    .enable (st.enable),
    .trap   (op_trap)
  );

  fcsr_trap_eval #(.N_EN(N_IEEE)) u_wr_trap (
    .cause  (wr_view.cause),
    .enable (wr_view.enable),
    .trap   (wr_trap)
  );

  fcsr_read_port u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (ctl_rd_valid),
    .rd_idx      (ctl_rd_idx),
    .rd_gpr      (ctl_rd_gpr),
    .status_word (word_now),
    .rsp_valid   (rd_rsp_valid),
    .rsp_gpr     (rd_rsp_gpr),
    .rsp_data    (rd_rsp_data)
  );

  assign round_mode   = st.rm;
  assign flush_denorm = st.flush;
  assign wb_suppress  = op_fire && op_trap;
  assign trap_req     = (op_fire && op_trap) || (wr_fire && wr_trap);

  AST_SUPPRESS_WITH_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_suppress |-> trap_req && op_valid); // R7

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !ctl_wr_ready); // R9

  AST_NO_IDLE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !ctl_wr_valid |-> !trap_req && !wb_suppress); // R8

  AST_RM_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> round_mode == $past(ctl_wr_data[1:0]) && flush_denorm == $past(ctl_wr_data[24])); // R2
endmodule

// File: tb/fpu_ctrl_status_tb.sv
module fpu_ctrl_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_valid = 1'b0;
  logic        ctl_wr_ready;
  logic [4:0]  ctl_wr_idx = '0;
  logic [31:0] ctl_wr_data = '0;
  logic        ctl_rd_valid = 1'b0;
  logic [4:0]  ctl_rd_idx = '0;
  logic [4:0]  ctl_rd_gpr = '0;
  logic        rd_rsp_valid;
  logic [4:0]  rd_rsp_gpr;
  logic [31:0] rd_rsp_data;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [5:0]  op_exc = '0;
  logic [1:0]  round_mode;
  logic        flush_denorm;
  logic        trap_req;
  logic        wb_suppress;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] model = '0;
  localparam logic [31:0] WMASK = 32'h0103_FFFF;

  always #10 clk = ~clk;

  fpu_ctrl_status u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic trap_of(input logic [5:0] cause, input logic [4:0] en);
    return (|(cause[4:0] & en)) | cause[5];
  endfunction

  task automatic step(input logic wv, input logic [4:0] widx, input logic [31:0] wdata,
                      input logic rv, input logic [4:0] ridx, input logic [4:0] rgpr,
                      input logic ov, input logic [5:0] oexc);
    logic [31:0] exp_rd;
    logic exp_rv, exp_trap, exp_sup, wacc;
    @(negedge clk);
    ctl_wr_valid = wv; ctl_wr_idx = widx; ctl_wr_data = wdata;
    ctl_rd_valid = rv; ctl_rd_idx = ridx; ctl_rd_gpr = rgpr;
    op_valid = ov; op_exc = oexc;
    #2;
    wacc = wv && !ov && (widx == 5'd31);
    exp_sup  = ov && trap_of(oexc, model[11:7]);
    exp_trap = exp_sup || (wacc && trap_of(wdata[17:12], wdata[11:7]));
    chk("R9 op_ready", {31'b0, op_ready}, 32'd1);
    chk("R9 ctl_wr_ready", {31'b0, ctl_wr_ready}, {31'b0, !ov});
    chk("R7/R8 trap_req", {31'b0, trap_req}, {31'b0, exp_trap});
    chk("R7 wb_suppress", {31'b0, wb_suppress}, {31'b0, exp_sup});
    exp_rv = rv && (rgpr != 0);
    exp_rd = (ridx == 5'd31) ? model : 32'd0;
    if (wacc) model = wdata & WMASK;
    else if (ov) model = {model[31:18], oexc, model[11:7], model[6:2] | oexc[4:0], model[1:0]};
    @(posedge clk);
    #1;
    chk("R4 rsp_valid", {31'b0, rd_rsp_valid}, {31'b0, exp_rv});
    if (exp_rv) begin
      chk("R4 rsp_gpr", {27'b0, rd_rsp_gpr}, {27'b0, rgpr});
      chk("R3/R5/R6 rsp_data", rd_rsp_data, exp_rd);
    end
    chk("R2 round_mode", {30'b0, round_mode}, {30'b0, model[1:0]});
    chk("R2 flush_denorm", {31'b0, flush_denorm}, {31'b0, model[24]});
  endtask

  task automatic rd31(); step(0, 0, 0, 1, 5'd31, 5'd3, 0, 0); endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 round_mode", {30'b0, round_mode}, 32'd0);
    chk("R1 flush", {31'b0, flush_denorm}, 32'd0);
    chk("R1 trap", {31'b0, trap_req}, 32'd0);
    rd31(); rd31();
    // R2: writable mask, round mode, flush
    step(1, 5'd31, 32'hFEFC_0002, 0, 0, 0, 0, 0);
    rd31(); rd31();
    step(1, 5'd31, 32'h0100_0003, 0, 0, 0, 0, 0);
    // R3: revision read zero and stray index, write to other index ignored
    step(0, 0, 0, 1, 5'd0, 5'd7, 0, 0);
    step(0, 0, 0, 1, 5'd12, 5'd7, 0, 0);
    step(1, 5'd5, 32'h0000_0001, 0, 0, 0, 0, 0);
    rd31(); rd31();
    // R4: gpr 0 discarded
    step(0, 0, 0, 1, 5'd31, 5'd0, 0, 0);
    // R7: enable invalid only; shifted-enable corner
    step(1, 5'd31, 32'h0000_0800, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 6'b001000);
    step(0, 0, 0, 0, 0, 0, 1, 6'b010000);
    step(0, 0, 0, 0, 0, 0, 1, 6'b100000);
    // R5/R6: cause rewrite, flags accumulate
    step(0, 0, 0, 0, 0, 0, 1, 6'b000011);
    step(0, 0, 0, 0, 0, 0, 1, 6'b000000);
    rd31(); rd31();
    // R8: write trapping itself; write with disjoint cause/enable
    step(1, 5'd31, 32'h0000_1080, 0, 0, 0, 0, 0);
    step(1, 5'd31, 32'h0000_2080, 0, 0, 0, 0, 0);
    step(1, 5'd31, 32'h0002_0000, 0, 0, 0, 0, 0);
    // R9: write offered during op is held off
    step(1, 5'd31, 32'h0000_0F83, 0, 0, 0, 1, 6'b000001);
    rd31(); rd31();
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], (r[2] ? 5'd31 : r[7:3]), $urandom & (r[8] ? 32'hFFFF_FFFF : 32'h0100_0FFF),
           r[9], (r[10] ? 5'd31 : r[15:11]), (r[16] ? 5'd0 : r[21:17] | 5'd1),
           r[22] | r[23], (r[24] ? r[30:25] : {1'b0, r[29:25]} & 6'h1F));
    end
    rd31(); rd31();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule